// File: doc/BRIEF.md
# Multi-port polled cell receive master

This block sits on the cell-layer side of a byte-wide receive bus that several PHY ports share. It steps a poll address over the ports every cycle and reads each port's cell-ready answer two edges later. When a port is ready, it selects that port by driving its index with the read enable low for one cycle. It then holds the read enable high for one cell's worth of cycles. The bytes that come back are framed by a start-of-cell strobe. They leave the block on a simple byte stream that carries a port tag and start, end and error markers.

Polling continues while a cell is being read, so the next port is already known when the current read window closes. The next selection is made in the same cycle the enable drops. Between two consecutive cells there is then exactly one idle byte slot on the bus. When more than one port is ready, the next one is taken in rotating order, starting after the port served last. Ready answers that could still describe a cell already taken are ignored, so a port is never selected for a cell it no longer holds.

Top module: `cell_poll_rx`

## Requirements
- R1: While the read enable is high, the poll address (a port index, 0 to NPORT-1) moves to the next index every cycle, wrapping from NPORT-1 to 0, so every port is polled during each read window.
- R2: A port is selected only after a poll of it was answered ready; the answer sampled on an edge belongs to the address driven two edges earlier. Selection drives the port's index with the enable low for one cycle and raises the enable on the next edge. No enable is raised while no port is ready.
- R3: Each selection keeps the read enable high for exactly CELL_LEN consecutive cycles.
- R4: A byte sampled on an edge is accepted when the enable was high two edges earlier. It appears on the output one cycle later with valid high and the tag of the port that sent it. The start marker is set on a byte that arrives with the start strobe, and the end marker on the CELL_LEN-th byte of a cell.
- R5: When several ports are ready, the next port served is the first ready one after the port served last, in increasing index order with wrap-around.
- R6: When another port is ready as a window closes, the next selection occurs in the cycle the enable drops. The next cell's start marker then follows its predecessor's end marker by exactly two cycles.
- R7: Bytes accepted outside a cell (after the CELL_LEN-th byte and before the next start strobe) are dropped: no valid output and no error.
- R8: A start strobe inside an unfinished cell raises the error output together with the start marker on that byte, and the byte count restarts from it.
- R9: During reset, the enable, valid, start, end and error outputs are low.
- R10: Ready answers for the selected port that come from polls issued before or during its select cycle are ignored, so a port holding a single cell is served once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| poll_addr | output | AW | Poll/select port index |
| rd_en | output | 1 | Read enable to the selected port |
| port_avail | input | 1 | Cell-ready answer for the address polled two edges earlier |
| rx_data | input | DW | Received cell byte |
| rx_soc | input | 1 | Start-of-cell strobe for rx_data |
| cell_valid | output | 1 | Output byte valid |
| cell_data | output | DW | Output byte |
| cell_sop | output | 1 | First byte of a cell |
| cell_eop | output | 1 | CELL_LEN-th byte of a cell |
| cell_port | output | AW | Port tag of the output byte |
| cell_err | output | 1 | Start strobe seen inside an unfinished cell |

## Verification
The bench builds the block with its defaults: four ports and 52-byte cells on an 8-bit bus. Four ports make a full rotation run from port 2 through 3, 0, 1 and back to 2. This shows both the wrap of the rotation and a port served twice in one burst. The 52-cycle window is long enough for every port to be polled and found ready before the window closes, so the back-to-back spacing and the mid-cell restart at byte 20 can both be reached.

// File: rtl/cell_poll_rx.sv
module cell_poll_rx #(
  parameter int NPORT = 4,
  parameter int CELL_LEN = 52,
  parameter int DW = 8,
  localparam int AW = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int CW = $clog2(CELL_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] poll_addr,
  output logic          rd_en,
  input  logic          port_avail,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_soc,
  output logic          cell_valid,
  output logic [DW-1:0] cell_data,
  output logic          cell_sop,
  output logic          cell_eop,
  output logic [AW-1:0] cell_port,
  output logic          cell_err
);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    return (a == AW'(NPORT - 1)) ? '0 : a + 1'b1;
  endfunction

  logic [NPORT-1:0] rdy;
  logic [AW-1:0]    pcnt, cur, poll_q1, cur_q1, pick, scan;
  logic [CW-1:0]    rcnt, bcnt;
  logic [1:0]       hold;
  logic             selq, ren_d1, in_cell, any;

  always_comb begin
    any  = 1'b0;
    pick = cur;
    scan = cur;
    for (int k = 0; k < NPORT; k++) begin
      scan = step(scan);
      if (!any && rdy[scan]) begin
        any  = 1'b1;
        pick = scan;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_addr <= '0;
      rd_en     <= 1'b0;
      selq      <= 1'b0;
      rcnt      <= '0;
      pcnt      <= '0;
      cur       <= '0;
      hold      <= '0;
      rdy       <= '0;
      poll_q1   <= '0;
      ren_d1    <= 1'b0;
      cur_q1    <= '0;
    end else begin
      poll_q1 <= poll_addr;
      ren_d1  <= rd_en;
      cur_q1  <= cur;
      if (hold != 2'd0) hold <= hold - 1'b1;
      if (!(poll_q1 == cur && hold != 2'd0)) rdy[poll_q1] <= port_avail;
      if (selq) begin
        selq      <= 1'b0;
        rd_en     <= 1'b1;
        rcnt      <= '0;
        poll_addr <= pcnt;
        pcnt      <= step(pcnt);
      end else if (rd_en && rcnt != CW'(CELL_LEN - 1)) begin
        rcnt      <= rcnt + 1'b1;
        poll_addr <= pcnt;
        pcnt      <= step(pcnt);
      end else begin
        rd_en <= 1'b0;
        if (any) begin
          selq      <= 1'b1;
          cur       <= pick;
          poll_addr <= pick;
          rdy[pick] <= 1'b0;
          hold      <= 2'd2;
        end else begin
          poll_addr <= pcnt;
          pcnt      <= step(pcnt);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_valid <= 1'b0;
      cell_data  <= '0;
      cell_sop   <= 1'b0;
      cell_eop   <= 1'b0;
      cell_port  <= '0;
      cell_err   <= 1'b0;
      in_cell    <= 1'b0;
      bcnt       <= '0;
    end else begin
      cell_valid <= 1'b0;
      cell_sop   <= 1'b0;
      cell_eop   <= 1'b0;
      cell_err   <= 1'b0;
      if (ren_d1) begin
        if (rx_soc) begin
          cell_valid <= 1'b1;
          cell_sop   <= 1'b1;
          cell_err   <= in_cell;
          cell_data  <= rx_data;
          cell_port  <= cur_q1;
          in_cell    <= 1'b1;
          bcnt       <= CW'(1);
        end else if (in_cell) begin
          cell_valid <= 1'b1;
          cell_data  <= rx_data;
          cell_port  <= cur_q1;
          bcnt       <= bcnt + 1'b1;
          if (bcnt == CW'(CELL_LEN - 1)) begin
            cell_eop <= 1'b1;
            in_cell  <= 1'b0;
          end
        end
      end
    end
  end

endmodule

// File: rtl/cell_poll_rx_chk.sv
module cell_poll_rx_chk #(
  parameter int NPORT = 4,
  parameter int CELL_LEN = 52,
  localparam int AW = (NPORT > 1) ? $clog2(NPORT) : 1,
  localparam int CW = $clog2(CELL_LEN + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] poll_addr,
  input logic          rd_en,
  input logic          cell_valid,
  input logic          cell_sop,
  input logic          cell_eop,
  input logic          cell_err
);

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a == AW'(NPORT - 1)) ? '0 : a + 1'b1;
  endfunction

  logic [CW-1:0] run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run <= '0;
    else        run <= rd_en ? run + 1'b1 : '0;
  end

  // R1
  poll_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && $past(rd_en)) |-> poll_addr == nxt($past(poll_addr)));

  // R3
  ren_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> run < CW'(CELL_LEN));

  // R3
  ren_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_en) |-> run == CW'(CELL_LEN));

  // R4
  mark_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_sop || cell_eop) |-> cell_valid);

  // R8
  err_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cell_err |-> cell_sop);

endmodule

bind cell_poll_rx cell_poll_rx_chk #(.NPORT(NPORT), .CELL_LEN(CELL_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .poll_addr(poll_addr), .rd_en(rd_en),
  .cell_valid(cell_valid), .cell_sop(cell_sop), .cell_eop(cell_eop), .cell_err(cell_err)
);

// File: tb/sim_cell_poll_rx.sv
module sim_cell_poll_rx;
  localparam int NPORT = 4;
  localparam int CELL_LEN = 52;
  localparam int AW = $clog2(NPORT);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] poll_addr, cell_port;
  logic rd_en, port_avail, rx_soc, cell_valid, cell_sop, cell_eop, cell_err;
  logic [7:0] rx_data, cell_data;

  always #5 clk = ~clk;

  cell_poll_rx #(.NPORT(NPORT), .CELL_LEN(CELL_LEN), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .poll_addr(poll_addr), .rd_en(rd_en),
    .port_avail(port_avail), .rx_data(rx_data), .rx_soc(rx_soc),
    .cell_valid(cell_valid), .cell_data(cell_data), .cell_sop(cell_sop),
    .cell_eop(cell_eop), .cell_port(cell_port), .cell_err(cell_err));

  int nchk = 0, nfail = 0;
  task automatic chk(input bit ok, input string tag, input string msg);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s: %s", tag, msg); end
  endtask

  // PHY side: per-port queue of cells; kind 0 normal, -1 no strobe, k>0 extra strobe at byte k
  int kq [NPORT][$];
  int cyc = 0, ph_port = 0, ph_sel = 0, ph_idx = 0, ph_kind = 0, cellno = 0;
  bit ph_en = 0, prev_ren = 0;
  int prev_addr = 0;
  bit pend_v = 0, pend_s = 0;
  logic [7:0] pend_d = 0;
  int pend_p = 0;
  bit m_in = 0;
  int m_cnt = 0;
  int nsop = 0, neop = 0, nerr = 0, nren = 0, nclaim = 0, bad_claim = 0;
  int sop_p[$], sop_c[$], eop_c[$];
  logic [NPORT-1:0] poll_mask = '0;

  always @(negedge clk) begin
    cyc++;
    if (!rst_n) begin
      port_avail = 1'b0; rx_soc = 1'b0; rx_data = 8'h00; pend_v = 0;
    end else begin
      bit e_v, e_s, e_e, e_r, ok;
      string tag;
      e_v = 0; e_s = 0; e_e = 0; e_r = 0; tag = "R4";
      if (pend_v) begin
        if (pend_s) begin
          e_v = 1; e_s = 1; e_r = m_in;
          if (m_in) tag = "R8";
          m_in = 1; m_cnt = 1;
        end else if (m_in) begin
          e_v = 1; m_cnt++;
          if (m_cnt == CELL_LEN) begin e_e = 1; m_in = 0; end
        end else tag = "R7";
      end
      ok = (cell_valid == e_v) && (cell_sop == e_s) && (cell_eop == e_e) && (cell_err == e_r) &&
           (!e_v || (cell_data == pend_d && int'(cell_port) == pend_p));
      chk(ok, tag, $sformatf("cyc %0d v/s/e/err/d/p got %0b%0b%0b%0b %02h %0d exp %0b%0b%0b%0b %02h %0d",
          cyc, cell_valid, cell_sop, cell_eop, cell_err, cell_data, cell_port,
          e_v, e_s, e_e, e_r, pend_d, pend_p));
      if (e_s) begin sop_p.push_back(pend_p); sop_c.push_back(cyc); nsop++; if (e_r) nerr++; end
      if (e_e) begin eop_c.push_back(cyc); neop++; end

      if (prev_ren && !ph_en) begin
        ph_port = ph_sel; nclaim++; cellno++;
        if (kq[ph_port].size() == 0) begin bad_claim++; ph_kind = 0; end
        else ph_kind = kq[ph_port].pop_front();
        ph_idx = 0; ph_en = 1;
      end
      if (!prev_ren) begin ph_en = 0; ph_sel = prev_addr; end
      port_avail = kq[prev_addr].size() > 0;
      pend_v = prev_ren;
      if (prev_ren && ph_en && ph_idx < CELL_LEN) begin
        rx_data = 8'((ph_port * 64 + cellno * 5 + ph_idx) & 255);
        rx_soc = (ph_kind >= 0 && ph_idx == 0) || (ph_kind > 0 && ph_idx == ph_kind);
        ph_idx++;
      end else begin
        rx_data = 8'((cyc * 13) & 255); rx_soc = 1'b0;
      end
      pend_d = rx_data; pend_s = rx_soc; pend_p = ph_port;
      if (rd_en) begin nren++; poll_mask[poll_addr] = 1'b1; end
      prev_addr = int'(poll_addr); prev_ren = rd_en;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    #200000;
    nchk++; nfail++;
    $display("FAIL watchdog: run did not end, got hang exp completion");
    finish_run();
  end

  initial begin
    int n0, e0, r0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(!rd_en && !cell_valid && !cell_sop && !cell_eop && !cell_err, "R9",
        $sformatf("got en %0b v %0b err %0b exp all 0", rd_en, cell_valid, cell_err));
    @(negedge clk); rst_n = 1'b1;
    repeat (20) @(negedge clk);
    // R2 nothing ready: no enable
    chk(nren == 0, "R2", $sformatf("idle enable cycles got %0d exp 0", nren));

    kq[2].push_back(0);
    repeat (120) @(negedge clk);
    chk(nsop == 1 && sop_p[0] == 2, "R2", $sformatf("cells got %0d exp 1 from port 2", nsop));
    chk(neop == 1, "R4", $sformatf("complete cells got %0d exp 1", neop));
    chk(nren == CELL_LEN, "R3", $sformatf("enable cycles got %0d exp %0d", nren, CELL_LEN));
    chk(nclaim == 1, "R10", $sformatf("selections got %0d exp 1", nclaim));

    sop_p.delete(); sop_c.delete(); eop_c.delete(); poll_mask = '0;
    kq[2].push_back(0);
    repeat (15) @(negedge clk);
    kq[0].push_back(0); kq[1].push_back(0); kq[3].push_back(0); kq[2].push_back(0);
    repeat (400) @(negedge clk);
    chk(sop_p.size() == 5, "R5", $sformatf("cells got %0d exp 5", sop_p.size()));
    if (sop_p.size() == 5) begin
      int exp_p[5] = '{2, 3, 0, 1, 2};
      for (int i = 0; i < 5; i++)
        chk(sop_p[i] == exp_p[i], "R5", $sformatf("order slot %0d got %0d exp %0d", i, sop_p[i], exp_p[i]));
      for (int i = 1; i < 5; i++)
        chk(sop_c[i] - eop_c[i-1] == 2, "R6",
            $sformatf("gap before cell %0d got %0d exp 2", i, sop_c[i] - eop_c[i-1]));
    end
    chk(poll_mask == '1, "R1", $sformatf("polled mask got %b exp all ones", poll_mask));

    n0 = nsop; e0 = neop; r0 = nerr;
    kq[1].push_back(-1); kq[1].push_back(0);
    repeat (200) @(negedge clk);
    chk(nsop - n0 == 1 && neop - e0 == 1 && nerr == r0, "R7",
        $sformatf("sop/eop/err got %0d/%0d/%0d exp 1/1/0", nsop - n0, neop - e0, nerr - r0));

    n0 = nsop; e0 = neop; r0 = nerr;
    kq[3].push_back(20); kq[3].push_back(0);
    repeat (200) @(negedge clk);
    chk(nerr - r0 == 2 && nsop - n0 == 3 && neop - e0 == 1, "R8",
        $sformatf("err/sop/eop got %0d/%0d/%0d exp 2/3/1", nerr - r0, nsop - n0, neop - e0));

    chk(bad_claim == 0, "R10", $sformatf("selections of empty ports got %0d exp 0", bad_claim));
    chk(nren == CELL_LEN * nclaim, "R3",
        $sformatf("enable cycles got %0d exp %0d", nren, CELL_LEN * nclaim));
    finish_run();
  end
endmodule